// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the control logic for a five-stage in-order load/store pipeline. The stages are fetch, decode with register read, execute, memory access and writeback. Each cycle it reads the fields the pipeline latches hold: source specifiers and source-use flags of the instruction in decode, the destination, write-enable and load flag of the instruction in execute, and the destination, write-enable and memory-access flag of the instruction in the memory stage. It also reads the two operand values that decode reads for a branch compare.

From these fields it produces four kinds of control. The first is a bypass select for each execute-stage operand, chosen in decode and registered so that it is valid while the instruction sits in execute. The second is an interlock that freezes the PC and the decode latch while a no-op bubble enters execute. The third is a redirect and squash of the fetch latch when a branch resolves taken in decode; branches are predicted not taken. The fourth is a fetch hold when the memory stage occupies a memory port that fetch also uses.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: While `rst` is high, every single-cycle control output is 0. On the first edge with `rst` high both bypass selects become 0.
- R2: Bypass select encoding: 0 means register file, 1 means the execute/memory latch, 2 means the memory/writeback latch. A used decode source that equals the destination of a valid, writing, non-load instruction in execute gives select 1 on the next cycle.
- R3: A used decode source that equals the destination of a valid, writing instruction in the memory stage, with no execute match, gives select 2 on the next cycle.
- R4: When both the execute and memory stages match a source, the select is 1, because the younger producer wins.
- R5: Register 0, an unused source, an invalid producer and a non-writing producer never cause a bypass or a stall.
- R6: A used decode source that equals the destination of a load in execute raises `pc_hold`, `ifid_hold` and `ex_bubble` in the same cycle, with `ifid_flush` and `pc_redirect` low. Both selects are 0 on the next cycle.
- R7: Once the stalled load has moved to the memory stage, the held consumer receives select 2.
- R8: A valid branch in decode with equal operands and no stall raises `pc_redirect` and `ifid_flush` for exactly that cycle, with `pc_hold` low. With unequal operands none of the three is raised.
- R9: A branch in decode whose used source matches a writing instruction in execute or in the memory stage stalls as in R6 and does not redirect.
- R10: A stall overrides a branch squash. While `ifid_hold` is high, `ifid_flush` and `pc_redirect` are low.
- R11: With `SHARED_MEM`=1, a valid memory-stage instruction that accesses memory raises `pc_hold` and `ifid_flush` when there is no stall. If a taken branch occurs in the same cycle, `pc_redirect` is raised and `pc_hold` stays low.
- R12: An invalid decode slot raises no stall and no redirect, and it yields selects of 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds a live instruction |
| id_rs1 | input | RW | First source specifier in decode |
| id_rs2 | input | RW | Second source specifier in decode |
| id_use1 | input | 1 | First source is read |
| id_use2 | input | 1 | Second source is read |
| id_branch | input | 1 | Decode instruction is a conditional branch on equality |
| id_opa | input | DW | First operand value read in decode |
| id_opb | input | DW | Second operand value read in decode |
| ex_valid | input | 1 | Execute slot holds a live instruction |
| ex_rd | input | RW | Execute-stage destination |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_valid | input | 1 | Memory slot holds a live instruction |
| mem_rd | input | RW | Memory-stage destination |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_access | input | 1 | Memory-stage instruction reads or writes data memory |
| fwd_a | output | 2 | Registered bypass select for the first execute operand |
| fwd_b | output | 2 | Registered bypass select for the second execute operand |
| pc_hold | output | 1 | PC keeps its value |
| ifid_hold | output | 1 | Decode latch keeps its value |
| ifid_flush | output | 1 | Decode latch loads an invalid bubble |
| ex_bubble | output | 1 | Execute latch loads a no-op |
| pc_redirect | output | 1 | PC loads the branch target at the next edge |

## Verification
The checks assume that the latch fields are stable between edges and that a load in execute also has its write flag set. They also assume that a branch in decode marks both of its sources as used, and that the memory-access flag is only meaningful with the memory-stage valid bit. The random stimulus enforces these rules by construction: it forces `ex_wr` whenever `ex_load` is drawn and sets both use flags on every branch. It draws register specifiers from a small range so that matches, register-0 cases and double matches all occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_EXM = 2'd1,
    FWD_MWB = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/hz_match.sv
// Compares one decode source against one producer latch.
module hz_match #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic          use_src,
  input  logic          p_valid,
  input  logic          p_wr,
  input  logic [RW-1:0] p_rd,
  output logic          hit
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = use_src && p_valid && p_wr && (p_rd != ZERO_REG) && (p_rd == src);
  end
endmodule

// File: rtl/hz_interlock.sv
// Decides whether decode must wait, and whether a branch resolves taken.
module hz_interlock #(
  parameter int NSRC = 2,
  parameter int DW   = 32
) (
  input  logic            id_valid,
  input  logic            id_branch,
  input  logic [DW-1:0]   id_opa,
  input  logic [DW-1:0]   id_opb,
  input  logic [NSRC-1:0] hit_ex,
  input  logic [NSRC-1:0] hit_mem,
  input  logic            ex_load,
  output logic            stall,
  output logic            taken
);
  logic load_use;
  logic br_wait;

  always_comb begin
    // a load result is not ready before the end of the memory stage
    load_use = ex_load && (|hit_ex);
    // the branch compare reads the register file, so any in-flight producer blocks it
    br_wait  = id_branch && ((|hit_ex) || (|hit_mem));
    stall    = id_valid && (load_use || br_wait);
    taken    = id_valid && id_branch && (id_opa == id_opb) && !stall;
  end
endmodule

// File: rtl/hz_seq.sv
// Orders stall, squash and fetch-hold, and registers the bypass selects.
module hz_seq #(
  parameter bit SHARED_MEM = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic             stall,
  input  logic             taken,
  input  logic             mem_valid,
  input  logic             mem_access,
  input  hz_pkg::fwd_src_e pick_a,
  input  hz_pkg::fwd_src_e pick_b,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             ifid_flush,
  output logic             ex_bubble,
  output logic             pc_redirect
);
  import hz_pkg::*;

  logic port_busy;
  logic stall_q;
  logic taken_q;

  generate
    if (SHARED_MEM) begin : g_shared
      assign port_busy = mem_valid && mem_access;
    end else begin : g_split
      assign port_busy = 1'b0;
    end
  endgenerate

  always_comb begin
    stall_q     = stall && !rst;
    taken_q     = taken && !rst;
    ex_bubble   = stall_q;
    ifid_hold   = stall_q;
    pc_redirect = taken_q;
    pc_hold     = stall_q || (port_busy && !rst && !taken_q);
    ifid_flush  = !stall_q && (taken_q || (port_busy && !rst));
  end

  always_ff @(posedge clk) begin
    if (rst || stall || !id_valid) begin
      fwd_a <= FWD_RF;
      fwd_b <= FWD_RF;
    end else begin
      fwd_a <= pick_a;
      fwd_b <= pick_b;
    end
  end
endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl #(
  parameter int RW         = 5,
  parameter int DW         = 32,
  parameter bit SHARED_MEM = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_valid,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_branch,
  input  logic [DW-1:0] id_opa,
  input  logic [DW-1:0] id_opb,
  input  logic          ex_valid,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic          mem_valid,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_access,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_flush,
  output logic          ex_bubble,
  output logic          pc_redirect
);
  import hz_pkg::*;

  localparam int NSRC = 2;

  logic [RW-1:0]   srcs [NSRC];
  logic [NSRC-1:0] uses;
  logic [NSRC-1:0] hit_ex;
  logic [NSRC-1:0] hit_mem;
  fwd_src_e        pick [NSRC];
  logic            stall;
  logic            taken;

  assign srcs[0] = id_rs1;
  assign srcs[1] = id_rs2;
  assign uses    = {id_use2, id_use1};

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      hz_match #(.RW(RW)) u_ex (
        .src(srcs[s]), .use_src(uses[s]), .p_valid(ex_valid),
        .p_wr(ex_wr), .p_rd(ex_rd), .hit(hit_ex[s])
      );
      hz_match #(.RW(RW)) u_mem (
        .src(srcs[s]), .use_src(uses[s]), .p_valid(mem_valid),
        .p_wr(mem_wr), .p_rd(mem_rd), .hit(hit_mem[s])
      );
      // nearest producer first
      always_comb begin
        if (hit_ex[s])       pick[s] = FWD_EXM;
        else if (hit_mem[s]) pick[s] = FWD_MWB;
        else                 pick[s] = FWD_RF;
      end
    end
  endgenerate

  hz_interlock #(.NSRC(NSRC), .DW(DW)) u_lock (
    .id_valid(id_valid), .id_branch(id_branch), .id_opa(id_opa), .id_opb(id_opb),
    .hit_ex(hit_ex), .hit_mem(hit_mem), .ex_load(ex_load),
    .stall(stall), .taken(taken)
  );

  hz_seq #(.SHARED_MEM(SHARED_MEM)) u_seq (
    .clk(clk), .rst(rst), .id_valid(id_valid), .stall(stall), .taken(taken),
    .mem_valid(mem_valid), .mem_access(mem_access),
    .pick_a(pick[0]), .pick_b(pick[1]),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ifid_flush(ifid_flush), .ex_bubble(ex_bubble), .pc_redirect(pc_redirect)
  );
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int RW         = 5,
  parameter int DW         = 32,
  parameter bit SHARED_MEM = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          id_valid,
  input logic [RW-1:0] id_rs1,
  input logic          id_use1,
  input logic          id_branch,
  input logic [DW-1:0] id_opa,
  input logic [DW-1:0] id_opb,
  input logic          ex_valid,
  input logic [RW-1:0] ex_rd,
  input logic          ex_wr,
  input logic          ex_load,
  input logic          mem_valid,
  input logic          mem_access,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          ifid_flush,
  input logic          ex_bubble,
  input logic          pc_redirect
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

  assert_sel_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (fwd_a != 2'd3 && fwd_b != 2'd3));

  assert_young_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_use1 && ex_valid && ex_wr && ex_rd != '0 && ex_rd == id_rs1 && !ex_bubble)
    |=> fwd_a == 2'd1);

  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0) |=> fwd_a == 2'd0);

  assert_load_use_R6: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_use1 && ex_valid && ex_wr && ex_load && ex_rd != '0 && ex_rd == id_rs1)
    |-> (ex_bubble && pc_hold && ifid_hold && !ifid_flush && !pc_redirect));

  assert_bubble_sel_R6: assert property (@(posedge clk) disable iff (rst)
    ex_bubble |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

  assert_redirect_R8: assert property (@(posedge clk) disable iff (rst)
    pc_redirect |-> (ifid_flush && !pc_hold && id_valid && id_branch && id_opa == id_opb));

  assert_stall_wins_R10: assert property (@(posedge clk) disable iff (rst)
    ifid_hold |-> (!ifid_flush && !pc_redirect));

  assert_port_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (SHARED_MEM && mem_valid && mem_access && !ifid_hold) |-> ifid_flush);

  assert_idle_slot_R12: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> (!ifid_hold && !pc_redirect));
endmodule

bind hazard_fwd_ctrl hz_ctrl_chk #(.RW(RW), .DW(DW), .SHARED_MEM(SHARED_MEM)) u_chk (
  .clk(clk), .rst(rst), .id_valid(id_valid), .id_rs1(id_rs1), .id_use1(id_use1),
  .id_branch(id_branch), .id_opa(id_opa), .id_opb(id_opb),
  .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_load(ex_load),
  .mem_valid(mem_valid), .mem_access(mem_access),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
  .ifid_flush(ifid_flush), .ex_bubble(ex_bubble), .pc_redirect(pc_redirect)
);

// File: tb/sim_hazard_fwd_ctrl.sv
module sim_hazard_fwd_ctrl;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic id_valid = 0, id_use1 = 0, id_use2 = 0, id_branch = 0;
  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
  logic [DW-1:0] id_opa = '0, id_opb = '0;
  logic ex_valid = 0, ex_wr = 0, ex_load = 0;
  logic mem_valid = 0, mem_wr = 0, mem_access = 0;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, ifid_flush, ex_bubble, pc_redirect;

  int checks = 0;
  int errors = 0;
  logic [1:0] pend_a = 2'd0, pend_b = 2'd0;

  always #10 clk = ~clk;

  hazard_fwd_ctrl #(.RW(RW), .DW(DW), .SHARED_MEM(1'b1)) u0 (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use1(id_use1), .id_use2(id_use2), .id_branch(id_branch),
    .id_opa(id_opa), .id_opb(id_opb), .ex_valid(ex_valid), .ex_rd(ex_rd),
    .ex_wr(ex_wr), .ex_load(ex_load), .mem_valid(mem_valid), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_access(mem_access), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ifid_flush(ifid_flush),
    .ex_bubble(ex_bubble), .pc_redirect(pc_redirect)
  );

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic bit hit(logic [RW-1:0] s, logic u, logic pv, logic pw, logic [RW-1:0] prd);
    return u && pv && pw && (prd != 0) && (prd == s);
  endfunction

  function automatic logic [1:0] sel(bit hx, bit hm);
    return hx ? 2'd1 : (hm ? 2'd2 : 2'd0);
  endfunction

  // check outputs for the present inputs, then the registered selects one cycle later
  task automatic step(string tag);
    bit hx1, hx2, hm1, hm2, st, tk, busy;
    logic [6:0] exp_c, got_c;
    #1;
    hx1  = hit(id_rs1, id_use1, ex_valid, ex_wr, ex_rd);
    hx2  = hit(id_rs2, id_use2, ex_valid, ex_wr, ex_rd);
    hm1  = hit(id_rs1, id_use1, mem_valid, mem_wr, mem_rd);
    hm2  = hit(id_rs2, id_use2, mem_valid, mem_wr, mem_rd);
    st   = !rst && id_valid && ((ex_load && (hx1 || hx2)) || (id_branch && (hx1 || hx2 || hm1 || hm2)));
    tk   = !rst && id_valid && id_branch && (id_opa == id_opb) && !st;
    busy = !rst && mem_valid && mem_access;
    exp_c = {st || (busy && !tk), st, !st && (tk || busy), st, tk, 2'b00};
    got_c = {pc_hold, ifid_hold, ifid_flush, ex_bubble, pc_redirect, 2'b00};
    chk(tag, "pc_hold",     got_c[6], exp_c[6]);
    chk(tag, "ifid_hold",   got_c[5], exp_c[5]);
    chk(tag, "ifid_flush",  got_c[4], exp_c[4]);
    chk(tag, "ex_bubble",   got_c[3], exp_c[3]);
    chk(tag, "pc_redirect", got_c[2], exp_c[2]);
    pend_a = (rst || st || !id_valid) ? 2'd0 : sel(hx1, hm1);
    pend_b = (rst || st || !id_valid) ? 2'd0 : sel(hx2, hm2);
    @(negedge clk);
    chk(tag, "fwd_a", fwd_a, pend_a);
    chk(tag, "fwd_b", fwd_b, pend_b);
  endtask

  task automatic clear_in();
    id_valid = 0; id_use1 = 0; id_use2 = 0; id_branch = 0;
    id_rs1 = 0; id_rs2 = 0; id_opa = 0; id_opb = 1;
    ex_valid = 0; ex_wr = 0; ex_load = 0; ex_rd = 0;
    mem_valid = 0; mem_wr = 0; mem_access = 0; mem_rd = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    clear_in();
    // R1: hazardous inputs during reset produce nothing
    @(negedge clk);
    id_valid = 1; id_use1 = 1; id_rs1 = 3; ex_valid = 1; ex_wr = 1; ex_load = 1; ex_rd = 3;
    mem_valid = 1; mem_access = 1;
    step("R1");
    step("R1");
    rst = 0;
    clear_in();
    step("R1");

    // R2: execute-stage ALU producer
    id_valid = 1; id_use1 = 1; id_rs1 = 4; ex_valid = 1; ex_wr = 1; ex_rd = 4;
    step("R2"); chk("R2", "fwd_a direct", fwd_a, 1);
    // R3: memory-stage producer on second source
    clear_in(); id_valid = 1; id_use2 = 1; id_rs2 = 6; mem_valid = 1; mem_wr = 1; mem_rd = 6;
    step("R3"); chk("R3", "fwd_b direct", fwd_b, 2);
    // R4: both match, younger wins
    ex_valid = 1; ex_wr = 1; ex_rd = 6;
    step("R4"); chk("R4", "fwd_b direct", fwd_b, 1);
    // R5: register 0, unused source, non-writing producer
    clear_in(); id_valid = 1; id_use1 = 1; ex_valid = 1; ex_wr = 1; ex_load = 1;
    step("R5"); chk("R5", "no stall r0", ex_bubble, 0);
    clear_in(); id_valid = 1; id_rs1 = 7; ex_valid = 1; ex_wr = 1; ex_rd = 7;
    step("R5");
    clear_in(); id_valid = 1; id_use1 = 1; id_rs1 = 7; mem_valid = 1; mem_rd = 7;
    step("R5"); chk("R5", "fwd_a direct", fwd_a, 0);
    // R6 then R7: load-use interlock, then load moves on
    clear_in(); id_valid = 1; id_use1 = 1; id_rs1 = 9; ex_valid = 1; ex_wr = 1; ex_load = 1; ex_rd = 9;
    #1; chk("R6", "bubble direct", ex_bubble, 1); chk("R6", "hold direct", pc_hold, 1);
    step("R6"); chk("R6", "fwd_a direct", fwd_a, 0);
    ex_valid = 0; ex_load = 0; ex_wr = 0; mem_valid = 1; mem_wr = 1; mem_access = 1; mem_rd = 9;
    step("R7"); chk("R7", "fwd_a direct", fwd_a, 2);
    // R8: taken and not-taken branch
    clear_in(); id_valid = 1; id_branch = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 2; id_rs2 = 3;
    id_opa = 32'h55; id_opb = 32'h55;
    #1; chk("R8", "redirect direct", pc_redirect, 1); chk("R8", "flush direct", ifid_flush, 1);
    step("R8");
    id_opb = 32'h56;
    #1; chk("R8", "not taken redirect", pc_redirect, 0); chk("R8", "not taken flush", ifid_flush, 0);
    step("R8");
    // R9 and R10: dependent branch with equal operands stalls, no squash
    id_opb = 32'h55; mem_valid = 1; mem_wr = 1; mem_rd = 3;
    #1; chk("R9", "stall direct", ifid_hold, 1); chk("R10", "flush direct", ifid_flush, 0);
    step("R9");
    mem_valid = 0; ex_valid = 1; ex_wr = 1; ex_rd = 2;
    step("R10");
    // R11: shared port busy, alone and with a taken branch
    clear_in(); mem_valid = 1; mem_access = 1; id_valid = 1;
    #1; chk("R11", "hold direct", pc_hold, 1); chk("R11", "flush direct", ifid_flush, 1);
    step("R11");
    id_branch = 1; id_use1 = 1; id_use2 = 1; id_rs1 = 1; id_rs2 = 2; id_opa = 5; id_opb = 5;
    #1; chk("R11", "hold with branch", pc_hold, 0); chk("R11", "redirect with busy", pc_redirect, 1);
    step("R11");
    // R12: invalid decode slot
    clear_in(); id_use1 = 1; id_rs1 = 4; id_branch = 1; id_opa = 1; id_opb = 1;
    ex_valid = 1; ex_wr = 1; ex_load = 1; ex_rd = 4;
    step("R12"); chk("R12", "fwd_a direct", fwd_a, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      id_valid  = ($urandom % 5) != 0;
      id_branch = ($urandom % 4) == 0;
      id_rs1 = RW'($urandom % 4); id_rs2 = RW'($urandom % 4);
      id_use1 = id_branch | ($urandom % 2 == 1);
      id_use2 = id_branch | ($urandom % 2 == 1);
      id_opa = DW'($urandom % 2); id_opb = DW'($urandom % 2);
      ex_valid = $urandom % 2 == 1; ex_load = $urandom % 3 == 0;
      ex_wr = ex_load | ($urandom % 2 == 1); ex_rd = RW'($urandom % 4);
      mem_valid = $urandom % 2 == 1; mem_wr = $urandom % 2 == 1;
      mem_access = $urandom % 4 == 0; mem_rd = RW'($urandom % 4);
      rst = (i == 300);
      step("RAND");
    end
    rst = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule